// File: doc/BRIEF.md
# Local Launch-Aligned Scan-Enable Generator

This block lets delay tests launch from a shift without a fast global scan-enable network. A small two-flop cell sits in the scan chain and produces a local scan enable for the mux-scan flops placed after it. The global enable can fall slowly, at any point after the initialization shift, just as it would for a capture-launched test. The local enable stays high through the launch clock and drops exactly at the launch edge. So the launch clock shifts the chain, and the following clock captures functional responses.

The cell's two flops are preloaded during the initialization shift. The flop nearer the scan input is loaded with 0, and the flop nearer the driven cells is loaded with 1. The local enable is the OR of the global enable and the downstream cell flop. While the global enable is low, the upstream cell flop holds its value and the downstream flop copies it. The preloaded 0 therefore reaches the enable output at the launch edge. The module also contains a demonstration chain of one or more segments. Each segment is a cell followed by a run of mux-scan flops that take that cell's local enable. Between launch and capture, no clock edge may occur while the global enable is low.

Top module: `local_se_gen`

## Requirements
- R1: While reset is asserted (active low, asynchronous), every cell flop and chain flop reads 0, and each local enable equals the global enable.
- R2: While the global enable is 1, every local enable is 1. On each clock the whole chain shifts one place: scan input, then segment 0's upstream cell flop, its downstream cell flop, its chain flops 0 to SEG_LEN-1, then the next segment.
- R3: While the global enable is 0, a cell's upstream flop holds its value and its downstream flop takes the upstream value on each clock. A cell preloaded upstream 1 and downstream 0 therefore raises its local enable after one clock and keeps it high.
- R4: While the global enable is 0, a local enable is 1 exactly when its cell's downstream flop holds 1.
- R5: After a load that leaves upstream 0 and downstream 1 in each cell, the global enable falls and the next clock is the launch. At the launch each segment shifts: chain flop 0 takes 1, and chain flop i takes the old value of flop i-1.
- R6: After the launch edge the local enable is 0, and the next clock captures the functional inputs into the chain flops.
- R7: After capture both cell flops hold 0. Raising the global enable shifts the whole captured image out of the scan output, tail first.
- R8: Each segment's local enable depends only on its own cell, so different segments can switch at different edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gsen | input | 1 | Slow global scan enable |
| scan_in | input | 1 | Serial scan data into the first segment |
| func_d | input | NUM_SEG*SEG_LEN | Functional data captured by the chain flops |
| lsen | output | NUM_SEG | Local scan enable of each segment |
| q | output | NUM_SEG*SEG_LEN | Chain flop contents |
| scan_out | output | 1 | Serial scan data from the last chain flop |

## Verification
The central corner is the single clock between the fall of the global enable and capture. If the local enable followed the global enable directly, the launch edge would capture instead of shift, and the second vector would not be the one-bit shift of the first. If the cell dropped its enable one clock late, the capture edge would shift again. Two segments are preloaded with opposite cell values to show that their enables switch at different edges. A design whose upstream flop kept shifting instead of holding would let its enable fall back after one clock. Unloading after capture exposes a cell that fails to clear, or a scan order that skips or swaps positions.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  localparam int unsigned CELL_DEPTH = 2;

  typedef struct packed {
    logic head;
    logic tail;
  } cell_state_t;
endpackage

// File: rtl/lsg_rst_sync.sv
module lsg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lsg_launch_cell.sv
module lsg_launch_cell
  import lsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gsen,
  input  logic scan_in,
  output logic lsen,
  output logic scan_out
);
  cell_state_t st_q;
  cell_state_t st_d;

  // head loads only while the global enable is high; tail always follows head
  always_comb begin
    st_d      = st_q;
    st_d.tail = st_q.head;
    if (gsen) st_d.head = scan_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign lsen     = gsen | st_q.tail;
  assign scan_out = st_q.tail;
endmodule

// File: rtl/lsg_scan_flop.sv
module lsg_scan_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic se,
  input  logic sd,
  input  logic fd,
  output logic q
);
  logic d;

  always_comb begin
    d = se ? sd : fd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/local_se_gen.sv
module local_se_gen #(
  parameter int unsigned NUM_SEG = 2,
  parameter int unsigned SEG_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       gsen,
  input  logic                       scan_in,
  input  logic [NUM_SEG*SEG_LEN-1:0] func_d,
  output logic [NUM_SEG-1:0]         lsen,
  output logic [NUM_SEG*SEG_LEN-1:0] q,
  output logic                       scan_out
);
  localparam int unsigned TOTAL = NUM_SEG * SEG_LEN;

  logic               rst_n_sync;
  logic [NUM_SEG-1:0] seg_in;
  logic [NUM_SEG-1:0] cell_so;

  lsg_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    if (s == 0) begin : g_first
      assign seg_in[s] = scan_in;
    end else begin : g_next
      assign seg_in[s] = q[s*SEG_LEN-1];
    end

    lsg_launch_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .gsen    (gsen),
      .scan_in (seg_in[s]),
      .lsen    (lsen[s]),
      .scan_out(cell_so[s])
    );

    for (genvar f = 0; f < SEG_LEN; f++) begin : g_ff
      logic sd_w;
      if (f == 0) begin : g_head
        assign sd_w = cell_so[s];
      end else begin : g_body
        assign sd_w = q[s*SEG_LEN+f-1];
      end

      lsg_scan_flop u_ff (
        .clk  (clk),
        .rst_n(rst_n_sync),
        .se   (lsen[s]),
        .sd   (sd_w),
        .fd   (func_d[s*SEG_LEN+f]),
        .q    (q[s*SEG_LEN+f])
      );
    end
  end

  assign scan_out = q[TOTAL-1];
endmodule

// File: rtl/local_se_gen_sva.sv
module local_se_gen_sva #(
  parameter int unsigned NUM_SEG = 2,
  parameter int unsigned SEG_LEN = 4
) (
  input logic                       clk,
  input logic                       rst_ok,
  input logic                       gsen,
  input logic [NUM_SEG-1:0]         lsen,
  input logic [NUM_SEG*SEG_LEN-1:0] q,
  input logic [NUM_SEG*SEG_LEN-1:0] func_d,
  input logic                       scan_out
);
  localparam int unsigned TOTAL = NUM_SEG * SEG_LEN;

  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    gsen |-> (lsen == {NUM_SEG{1'b1}}));

  if (SEG_LEN > 1) begin : g_shift
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_ok)
      lsen[0] |=> (q[1] == $past(q[0])));
  end

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    !lsen[0] |=> (q[0] == $past(func_d[0])));

  if (TOTAL > 1) begin : g_unload
    p_unload_r7: assert property (@(posedge clk) disable iff (!rst_ok)
      lsen[NUM_SEG-1] |=> (scan_out == $past(q[TOTAL-2])));
  end
endmodule

bind local_se_gen local_se_gen_sva #(
  .NUM_SEG(NUM_SEG),
  .SEG_LEN(SEG_LEN)
) u_sva (
  .clk     (clk),
  .rst_ok  (rst_n_sync),
  .gsen    (gsen),
  .lsen    (lsen),
  .q       (q),
  .func_d  (func_d),
  .scan_out(scan_out)
);

// File: tb/local_se_gen_bench.sv
module local_se_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int SL = 4;
  localparam int N  = NS * SL;
  localparam int T  = NS * (SL + 2);

  logic         clk = 1'b0;
  logic         rst_n;
  logic         gsen;
  logic         scan_in;
  logic [N-1:0] func_d;
  logic [NS-1:0] lsen;
  logic [N-1:0] q;
  logic         scan_out;

  int checks = 0;
  int errors = 0;
  int m_a[NS];
  int m_b[NS];
  int m_q[N];
  int img[T];

  always #(CLK_PERIOD/2) clk = ~clk;

  local_se_gen #(.NUM_SEG(NS), .SEG_LEN(SL)) u_local_se_gen (
    .clk(clk), .rst_n(rst_n), .gsen(gsen), .scan_in(scan_in),
    .func_d(func_d), .lsen(lsen), .q(q), .scan_out(scan_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_lsen();
    int v = 0;
    for (int s = 0; s < NS; s++) if (gsen || m_b[s] != 0) v |= (1 << s);
    return v;
  endfunction

  function automatic int exp_q();
    int v = 0;
    for (int i = 0; i < N; i++) if (m_q[i] != 0) v |= (1 << i);
    return v;
  endfunction

  task automatic model_clear();
    for (int s = 0; s < NS; s++) begin m_a[s] = 0; m_b[s] = 0; end
    for (int i = 0; i < N; i++) m_q[i] = 0;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    for (int s = NS - 1; s >= 0; s--) begin
      int en = (gsen || m_b[s] != 0) ? 1 : 0;
      int sin = (s == 0) ? int'(scan_in) : m_q[s*SL-1];
      for (int f = SL - 1; f >= 0; f--) begin
        int idx = s*SL + f;
        int src = (f == 0) ? m_b[s] : m_q[idx-1];
        m_q[idx] = en ? src : int'(func_d[idx]);
      end
      m_b[s] = m_a[s];
      if (gsen) m_a[s] = sin;
    end
    @(negedge clk);
    chk({tag, " lsen"}, int'(lsen), exp_lsen());
    chk({tag, " q"}, int'(q), exp_q());
    chk({tag, " scan_out"}, int'(scan_out), m_q[N-1]);
  endtask

  // build the scan image: per segment upstream cell, downstream cell, chain flops
  task automatic build_img(input int a0, input int b0, input int a1, input int b1,
                           input logic [N-1:0] v);
    for (int s = 0; s < NS; s++) begin
      int base = s * (SL + 2);
      img[base]   = (s == 0) ? a0 : a1;
      img[base+1] = (s == 0) ? b0 : b1;
      for (int f = 0; f < SL; f++) img[base+2+f] = int'(v[s*SL+f]);
    end
  endtask

  task automatic load_img();
    gsen = 1'b1;
    for (int k = 0; k < T; k++) begin
      scan_in = img[T-1-k][0];
      tick("R2 shift-in");
    end
    scan_in = 1'b0;
  endtask

  task automatic unload_check(input string tag);
    gsen = 1'b1;
    scan_in = 1'b0;
    for (int k = 0; k < T; k++) begin
      chk(tag, int'(scan_out), img[T-1-k]);
      tick(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    errors++;
    $display("FAIL watchdog R1 actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] v1;
    logic [N-1:0] shifted;
    rst_n = 1'b0; gsen = 1'b1; scan_in = 1'b0; func_d = '0;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1 reset q", int'(q), 0);
    chk("R1 reset scan_out", int'(scan_out), 0);
    chk("R1 reset lsen high", int'(lsen), 3);
    gsen = 1'b0; #1;
    chk("R1 reset lsen low", int'(lsen), 0);
    gsen = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick("R1 release");

    // launch-from-shift sequence
    v1 = 8'b1011_0110;
    build_img(0, 1, 0, 1, v1);
    load_img();
    chk("R2 loaded vector", int'(q), int'(v1));
    gsen = 1'b0; #1;
    chk("R4 enable held by cell", int'(lsen), 3);
    func_d = 8'b0101_1100;
    tick("R5 launch");
    for (int s = 0; s < NS; s++)
      for (int f = 0; f < SL; f++)
        shifted[s*SL+f] = (f == 0) ? 1'b1 : v1[s*SL+f-1];
    chk("R5 second vector is shift", int'(q), int'(shifted));
    chk("R6 enable low after launch", int'(lsen), 0);
    tick("R6 capture");
    chk("R6 captured functional", int'(q), int'(func_d));
    build_img(0, 0, 0, 0, func_d);
    func_d = '0;
    unload_check("R7 unload");

    // segments switching at different edges
    build_img(0, 1, 1, 0, 8'h3C);
    load_img();
    gsen = 1'b0; #1;
    chk("R8 per-segment enable", int'(lsen), 1);
    func_d = 8'hA5;
    tick("R8 first edge");
    chk("R3 enable rises from held head", int'(lsen), 2);
    tick("R3 second edge");
    chk("R3 head holds", int'(lsen), 2);
    func_d = '0;
    gsen = 1'b1;
    repeat (T) tick("R2 flush");

    // asynchronous reset mid-run
    build_img(1, 1, 1, 1, 8'hFF);
    load_img();
    #1 rst_n = 1'b0;
    #1;
    model_clear();
    chk("R1 async clear q", int'(q), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick("R1 after re-release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule